// File: doc/BRIEF.md
# Shift-Add One-Dimensional Inverse Block Transform

This block runs one pass of a separable inverse transform over a vector of up to eight signed 16-bit coefficients. It supports three kernels: a 4-point inverse sine transform, a 4-point inverse cosine transform and an 8-point inverse cosine transform. The 8-point kernel reuses the 4-point cosine datapath for its even-indexed inputs and adds an odd section and a final butterfly.

The datapath contains no multipliers. Each input lane builds one small set of shifted and summed copies of itself: 2x, 4x, 9x, 18x, 36x, 64x and 90x. Every kernel constant is then put together from that set. The accumulated sums are rounded, shifted right and clamped to 16 bits.

A two-dimensional inverse transform feeds the same unit twice: first the columns, with the first-pass shift, then the rows, with the second-pass shift. Any transpose storage between the two passes sits outside this block. One vector may enter on every clock cycle. The result appears exactly two cycles later, whatever the kernel.

Top module: `itx_1d`

## Requirements
- R1: While reset is held, and after it, until the first result is produced, `out_valid` is 0 and every `out_res` lane is 0.
- R2: With `in_size8`=0 and `in_dst`=0, input lanes 0..3 are cosine coefficients s0..s3. Output lane n is the rounded value of the sum over k of C4[k][n]*s_k. The rows of C4 are (64,64,64,64), (83,36,-36,-83), (64,-64,-64,64) and (36,-83,83,-36).
- R3: With `in_size8`=0 and `in_dst`=1, output lane n is the rounded value of the sum over k of S4[k][n]*s_k. The rows of S4 are (29,55,74,84), (74,74,0,-74), (84,-29,-74,55) and (55,-84,74,-29).
- R4: With `in_size8`=1, input lanes 0..7 are s0..s7. Output lane n is the rounded value of the sum over k of C8[k][n]*s_k. The 8-point cosine matrix uses the even constants 64, 83, 36 and the odd constants 89, 75, 50, 18 in their usual sign pattern.
- R5: With `in_pass2`=0, every sum has 64 added to it and is then shifted arithmetically right by 7.
- R6: With `in_pass2`=1, every sum has 2^(11-BIT_DEPTH+8) added to it and is shifted right by 20-BIT_DEPTH. With the default BIT_DEPTH of 8 this is an offset of 2048 and a shift of 12.
- R7: A rounded value above 32767 comes out as 32767, and one below -32768 comes out as -32768.
- R8: A vector accepted with `in_valid`=1 at a clock edge produces `out_valid`=1 with its result exactly two edges later, in every mode. Back-to-back vectors give back-to-back results, and `out_valid` is never 1 without that cause.
- R9: In the 4-point modes, input lanes 4..7 have no effect, and output lanes 4..7 are 0.
- R10: With `in_size8`=1, `in_dst` has no effect, and the 8-point cosine result is produced.
- R11: In cycles where `out_valid` is 0, `out_res` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The input vector and mode bits are valid this cycle |
| in_size8 | input | 1 | 1 selects the 8-point kernel, 0 a 4-point kernel |
| in_dst | input | 1 | In 4-point mode, 1 selects the sine kernel |
| in_pass2 | input | 1 | 1 selects the second-pass rounding shift |
| in_coef | input | 128 | Eight 16-bit signed coefficients; lane i is bits [16i+15:16i] |
| out_valid | output | 1 | `out_res` carries a new result |
| out_res | output | 128 | Eight 16-bit signed results, packed like `in_coef` |

## Verification
Some properties are checked by assertions on every cycle. These are the fixed two-cycle link between `in_valid` and `out_valid` in both directions, the zero upper lanes after a 4-point vector, and the held output while `out_valid` is low. The numeric content can only be shown by the bench scenarios. That content covers each kernel's matrix, the rounding offset and shift of each pass, clamping at both rails, the ignored sine select in 8-point mode and the ignored upper inputs in 4-point mode. The bench compares those results against a matrix model that uses true products.

// File: rtl/itx_pkg.sv
// Shared widths and types for the shift-add inverse transform.
// Assumes 16-bit coefficients; the accumulator width covers the largest
// constant row sum (479) times full-scale input, with margin.
package itx_pkg;
    localparam int COEF_W = 16;
    localparam int ACC_W  = COEF_W + 10;
    localparam int LANES  = 8;

    typedef logic signed [ACC_W-1:0] acc_t;

    // Constant products of one input lane, built from the shared shift-add pool.
    typedef struct packed {
        acc_t m18;
        acc_t m29;
        acc_t m36;
        acc_t m50;
        acc_t m55;
        acc_t m64;
        acc_t m74;
        acc_t m75;
        acc_t m83;
        acc_t m84;
        acc_t m89;
    } prod_t;
endpackage

// File: rtl/itx_products.sv
// Forms every kernel constant product of one coefficient without multipliers.
// Assumes: combinational; the caller registers the result.
module itx_products
    import itx_pkg::*;
(
    input  logic signed [COEF_W-1:0] x,
    output prod_t                    p
);
    acc_t x1, p2, p4, p9, p18, p36, p64, p90;

    // Shared pool: a handful of shifted terms, reused by every constant.
    always_comb begin
        x1  = acc_t'(x);
        p2  = x1 <<< 1;
        p4  = x1 <<< 2;
        p9  = (x1 <<< 3) + x1;
        p18 = p9 <<< 1;
        p36 = p9 <<< 2;
        p64 = x1 <<< 6;
        p90 = (p9 <<< 3) + p18;
    end

    // Kernel constants as sums of pool terms.
    always_comb begin
        p.m18 = p18;
        p.m29 = p18 + p9 + p2;
        p.m36 = p36;
        p.m50 = p36 + p9 + p4 + x1;
        p.m55 = p36 + p18 + x1;
        p.m64 = p64;
        p.m74 = p64 + p9 + x1;
        p.m75 = p64 + p9 + p2;
        p.m83 = p64 + p18 + x1;
        p.m84 = p64 + p18 + p2;
        p.m89 = p90 - x1;
    end
endmodule

// File: rtl/itx_butterfly.sv
// Combines lane products into eight sums for the selected kernel.
// Assumes: combinational; the 8-point cosine reuses the 4-point even core
// on lanes 0,2,4,6; 4-point modes leave sums 4..7 at zero.
module itx_butterfly
    import itx_pkg::*;
(
    input  prod_t [LANES-1:0] lp,
    input  logic              size8,
    input  logic              dst,
    output acc_t  [LANES-1:0] acc
);
    prod_t pa, pb, pc, pd;
    acc_t  e0, e1, o0, o1;
    acc_t  ev [4];
    acc_t  od [4];
    acc_t  ds [4];

    // Route inputs to the 4-point even core according to the size.
    always_comb begin
        pa = lp[0];
        pb = size8 ? lp[2] : lp[1];
        pc = size8 ? lp[4] : lp[2];
        pd = size8 ? lp[6] : lp[3];
    end

    // 4-point cosine core (also the even half of the 8-point kernel).
    always_comb begin
        e0 = pa.m64 + pc.m64;
        e1 = pa.m64 - pc.m64;
        o0 = pb.m83 + pd.m36;
        o1 = pb.m36 - pd.m83;
        ev[0] = e0 + o0;
        ev[1] = e1 + o1;
        ev[2] = e1 - o1;
        ev[3] = e0 - o0;
    end

    // 8-point odd section over lanes 1,3,5,7.
    always_comb begin
        od[0] = lp[1].m89 + lp[3].m75 + lp[5].m50 + lp[7].m18;
        od[1] = lp[1].m75 - lp[3].m18 - lp[5].m89 - lp[7].m50;
        od[2] = lp[1].m50 - lp[3].m89 + lp[5].m18 + lp[7].m75;
        od[3] = lp[1].m18 - lp[3].m50 + lp[5].m75 - lp[7].m89;
    end

    // 4-point sine kernel.
    always_comb begin
        ds[0] = lp[0].m29 + lp[1].m74 + lp[2].m84 + lp[3].m55;
        ds[1] = lp[0].m55 + lp[1].m74 - lp[2].m29 - lp[3].m84;
        ds[2] = lp[0].m74 - lp[2].m74 + lp[3].m74;
        ds[3] = lp[0].m84 - lp[1].m74 + lp[2].m55 - lp[3].m29;
    end

    // Output butterfly and kernel selection.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            if (size8) begin
                acc[k]         = ev[k] + od[k];
                acc[LANES-1-k] = ev[k] - od[k];
            end else begin
                acc[k]         = dst ? ds[k] : ev[k];
                acc[LANES-1-k] = '0;
            end
        end
    end
endmodule

// File: rtl/itx_scale.sv
// Rounds, shifts and clamps one sum to a 16-bit signed result.
// Assumes: combinational; both shifts are at least 1.
module itx_scale
    import itx_pkg::*;
#(
    parameter int SH_FIRST  = 7,
    parameter int SH_SECOND = 12
) (
    input  acc_t                     a,
    input  logic                     pass2,
    output logic signed [COEF_W-1:0] y
);
    localparam acc_t RND_FIRST  = acc_t'(1) <<< (SH_FIRST - 1);
    localparam acc_t RND_SECOND = acc_t'(1) <<< (SH_SECOND - 1);
    localparam acc_t TOP_V      = acc_t'((1 <<< (COEF_W - 1)) - 1);
    localparam acc_t BOT_V      = -acc_t'(1 <<< (COEF_W - 1));

    acc_t r;

    // Rounding offset plus arithmetic shift for the selected pass.
    always_comb begin
        r = pass2 ? ((a + RND_SECOND) >>> SH_SECOND) : ((a + RND_FIRST) >>> SH_FIRST);
    end

    // Clamp to the signed output range.
    always_comb begin
        if (r > TOP_V)      y = TOP_V[COEF_W-1:0];
        else if (r < BOT_V) y = BOT_V[COEF_W-1:0];
        else                y = r[COEF_W-1:0];
    end
endmodule

// File: rtl/itx_1d.sv
// One pass of the multiplierless inverse transform (4-pt sine, 4/8-pt cosine).
// Stage 1 registers the per-lane constant products; stage 2 registers the
// rounded, clamped butterfly result. Latency is two cycles in every mode and
// a new vector may enter every cycle. Assumes BIT_DEPTH between 8 and 12.
module itx_1d
    import itx_pkg::*;
#(
    parameter int BIT_DEPTH   = 8,
    parameter int FIRST_SHIFT = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_size8,
    input  logic                      in_dst,
    input  logic                      in_pass2,
    input  logic [LANES*COEF_W-1:0]   in_coef,
    output logic                      out_valid,
    output logic [LANES*COEF_W-1:0]   out_res
);
    localparam int SECOND_SHIFT = 20 - BIT_DEPTH;
    localparam int HALF_W       = (LANES / 2) * COEF_W;

    prod_t [LANES-1:0] prod_d;
    prod_t [LANES-1:0] prod_q;
    acc_t  [LANES-1:0] acc;
    logic  [LANES*COEF_W-1:0] res_d;
    logic  v_q, size8_q, dst_q, pass2_q;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            itx_products u_prod (
                .x (in_coef[g*COEF_W +: COEF_W]),
                .p (prod_d[g])
            );
            itx_scale #(
                .SH_FIRST  (FIRST_SHIFT),
                .SH_SECOND (SECOND_SHIFT)
            ) u_scale (
                .a     (acc[g]),
                .pass2 (pass2_q),
                .y     (res_d[g*COEF_W +: COEF_W])
            );
        end
    endgenerate

    itx_butterfly u_bfly (
        .lp    (prod_q),
        .size8 (size8_q),
        .dst   (dst_q),
        .acc   (acc)
    );

    // Stage 1: capture products and mode bits of an accepted vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q     <= 1'b0;
            size8_q <= 1'b0;
            dst_q   <= 1'b0;
            pass2_q <= 1'b0;
            prod_q  <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                size8_q <= in_size8;
                dst_q   <= in_dst;
                pass2_q <= in_pass2;
                prod_q  <= prod_d;
            end
        end
    end

    // Stage 2: publish the scaled result; hold it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= v_q;
            if (v_q) out_res <= res_d;
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);                                   // R8
    AST_NO_ORPHAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));                             // R8
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_size8, 2)) |-> (out_res[LANES*COEF_W-1:HALF_W] == '0)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_res));                              // R11
endmodule

// File: tb/test_itx_1d.sv
// Directed bench for itx_1d: one task per scenario, matrix reference model.
module test_itx_1d;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_size8 = 1'b0;
    logic         in_dst = 1'b0;
    logic         in_pass2 = 1'b0;
    logic [127:0] in_coef = '0;
    logic         out_valid;
    logic [127:0] out_res;

    int n_chk = 0;
    int n_bad = 0;
    int seed = 12345;

    always #2.5 clk = ~clk;

    itx_1d i_itx_1d (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_size8  (in_size8),
        .in_dst    (in_dst),
        .in_pass2  (in_pass2),
        .in_coef   (in_coef),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    function automatic int c8(int k, int n);
        int r[8];
        case (k)
            0: r = '{64, 64, 64, 64, 64, 64, 64, 64};
            1: r = '{89, 75, 50, 18, -18, -50, -75, -89};
            2: r = '{83, 36, -36, -83, -83, -36, 36, 83};
            3: r = '{75, -18, -89, -50, 50, 89, 18, -75};
            4: r = '{64, -64, -64, 64, 64, -64, -64, 64};
            5: r = '{50, -89, 18, 75, -75, -18, 89, -50};
            6: r = '{36, -83, 83, -36, -36, 83, -83, 36};
            default: r = '{18, -50, 75, -89, 89, -75, 50, -18};
        endcase
        return r[n];
    endfunction

    function automatic int c4(int k, int n);
        int r[4];
        case (k)
            0: r = '{64, 64, 64, 64};
            1: r = '{83, 36, -36, -83};
            2: r = '{64, -64, -64, 64};
            default: r = '{36, -83, 83, -36};
        endcase
        return r[n];
    endfunction

    function automatic int s4(int k, int n);
        int r[4];
        case (k)
            0: r = '{29, 55, 74, 84};
            1: r = '{74, 74, 0, -74};
            2: r = '{84, -29, -74, 55};
            default: r = '{55, -84, 74, -29};
        endcase
        return r[n];
    endfunction

    // Reference: true-product matrix, round, shift, clamp (BIT_DEPTH = 8).
    function automatic logic [127:0] ref_vec(input logic [127:0] v, input bit s8, input bit dst, input bit p2);
        logic [127:0] o = '0;
        int np = s8 ? 8 : 4;
        int sh = p2 ? 12 : 7;
        for (int n = 0; n < np; n++) begin
            longint acc = 0;
            longint r;
            for (int k = 0; k < np; k++) begin
                longint sk = longint'($signed(v[k*16 +: 16]));
                int c = s8 ? c8(k, n) : (dst ? s4(k, n) : c4(k, n));
                acc += longint'(c) * sk;
            end
            r = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            o[n*16 +: 16] = r[15:0];
        end
        return o;
    endfunction

    function automatic logic [15:0] rnd16(int span);
        seed = seed * 1103515245 + 12345;
        return 16'(((seed >>> 8) % span));
    endfunction

    function automatic logic [127:0] rvec(int span);
        logic [127:0] v;
        for (int i = 0; i < 8; i++) v[i*16 +: 16] = rnd16(span);
        return v;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one vector, wait two edges, compare the result.
    task automatic run_vec(input string req, input logic [127:0] v, input bit s8, input bit dst, input bit p2);
        @(negedge clk);
        in_valid = 1'b1; in_coef = v; in_size8 = s8; in_dst = dst; in_pass2 = p2;
        @(negedge clk);
        in_valid = 1'b0; in_coef = rvec(30000);
        @(negedge clk);
        check({req, " valid"}, 128'(out_valid), 128'(1));
        check(req, out_res, ref_vec(v, s8, dst, p2));
    endtask

    task automatic t_reset;  // R1
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 128'(out_valid), 128'(0));
        check("R1 result in reset", out_res, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 128'(out_valid), 128'(0));
        check("R1 result after reset", out_res, '0);
    endtask

    task automatic t_dct4;  // R2, R5
        logic [127:0] v = '0;
        v[15:0] = 16'd1;
        run_vec("R5 round up s0=1", v, 0, 0, 0);
        check("R5 exact lanes", out_res, {64'h0, 16'd1, 16'd1, 16'd1, 16'd1});
        v[15:0] = 16'hFFFF;
        run_vec("R5 round s0=-1", v, 0, 0, 0);
        check("R5 exact zero", out_res, '0);
        for (int i = 0; i < 3; i++) run_vec("R2 dct4", rvec(4000), 0, 0, 0);
    endtask

    task automatic t_dst4;  // R3
        for (int i = 0; i < 3; i++) run_vec("R3 dst4", rvec(4000), 0, 1, 0);
    endtask

    task automatic t_dct8;  // R4
        for (int i = 0; i < 3; i++) run_vec("R4 dct8", rvec(4000), 1, 0, 0);
    endtask

    task automatic t_pass2;  // R6
        run_vec("R6 second pass dct8", rvec(30000), 1, 0, 1);
        run_vec("R6 second pass dst4", rvec(30000), 0, 1, 1);
        run_vec("R6 second pass dct4", rvec(30000), 0, 0, 1);
    endtask

    task automatic t_sat;  // R7
        run_vec("R7 clamp high", {8{16'h7FFF}}, 1, 0, 0);
        check("R7 lane0 high", 128'(out_res[15:0]), 128'(16'h7FFF));
        run_vec("R7 clamp low", {8{16'h8000}}, 1, 0, 0);
        check("R7 lane0 low", 128'(out_res[15:0]), 128'(16'h8000));
    endtask

    task automatic t_dst_ignored;  // R10
        logic [127:0] v = rvec(4000);
        run_vec("R10 dst ignored in 8-point", v, 1, 1, 0);
        check("R10 equals dct8", out_res, ref_vec(v, 1, 0, 0));
    endtask

    task automatic t_upper_lanes;  // R9
        logic [127:0] v = rvec(4000);
        logic [127:0] w = v;
        w[127:64] = rvec(30000) >> 64;
        run_vec("R9 upper inputs ignored", w, 0, 0, 0);
        check("R9 same as clean", out_res, ref_vec(v, 0, 0, 0));
        check("R9 upper outputs zero", 128'(out_res[127:64]), '0);
    endtask

    task automatic t_stream;  // R8
        logic [127:0] vs [4];
        bit s8s [4] = '{1, 0, 0, 1};
        bit dss [4] = '{0, 1, 0, 0};
        bit p2s [4] = '{0, 0, 1, 1};
        for (int i = 0; i < 4; i++) vs[i] = rvec(8000);
        for (int j = 0; j < 7; j++) begin
            @(negedge clk);
            if (j == 1) check("R8 not after one cycle", 128'(out_valid), 128'(0));
            if (j >= 2 && j < 6) begin
                check("R8 stream valid", 128'(out_valid), 128'(1));
                check("R8 stream data", out_res, ref_vec(vs[j-2], s8s[j-2], dss[j-2], p2s[j-2]));
            end
            if (j == 6) check("R8 stream ends", 128'(out_valid), 128'(0));
            if (j < 4) begin
                in_valid = 1'b1; in_coef = vs[j];
                in_size8 = s8s[j]; in_dst = dss[j]; in_pass2 = p2s[j];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_hold;  // R11
        logic [127:0] last;
        run_vec("R11 setup", rvec(4000), 1, 0, 0);
        last = out_res;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_coef = rvec(30000);
            in_size8 = ~in_size8;
            check("R11 idle valid", 128'(out_valid), 128'(0));
            check("R11 held result", out_res, last);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_dct4();
        t_dst4();
        t_dct8();
        t_pass2();
        t_sat();
        t_dst_ignored();
        t_upper_lanes();
        t_stream();
        t_hold();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule